// File: doc/BRIEF.md
# Write-Through Store Buffer

This block sits between a write-through data cache that does not allocate on write misses and the slower memory level below it. Each store the cache issues is parked in a small first-in, first-out queue of word-address, data and byte-enable entries. The writer does not wait for memory. The queue hands its entries to memory one at a time, in arrival order, over a valid/ready handshake. The writer is held back only when every slot is taken.

A read that misses in the cache must not return memory data that a parked store has already replaced. To prevent this, the memory word arriving for that read is presented to the block together with its word address. The block searches all pending entries and overlays the bytes of every matching entry. It applies them oldest to youngest, so the youngest store wins on each byte.

A store flagged as a cache miss goes only into the queue. One cycle after it is accepted, the block emits an invalidate strobe for the cache line selected by the store's index bits.

Top module: `wbuf_top`

## Requirements
- R1: After reset the queue is empty: `st_stall`, `mem_valid`, `inv_valid` and `lk_rvalid` are all low.
- R2: Accepted stores leave on the memory port in the order they arrived, with address, data and byte enables unchanged. `mem_valid` drops once the last entry has retired.
- R3: An entry retires only on a cycle where `mem_valid` and `mem_ready` are both high. While `mem_ready` stays low, the presented address, data and byte enables hold steady.
- R4: `st_stall` is high exactly while all DEPTH slots are occupied. A store presented while full is discarded when no drain happens in that cycle.
- R5: When the queue is full, a store and a drain in the same cycle are both accepted. `st_stall` stays high and the new store joins the tail.
- R6: The answer to a lookup appears one cycle after `lk_valid`, with `lk_rvalid` high. `lk_hit` is high when any entry pending in the lookup cycle has the requested word address.
- R7: In the lookup answer, byte lane i (bits 8i+7..8i) is taken from a matching pending entry whose byte-enable bit i is set, and from `lk_memdata` otherwise. When several entries match, they are applied oldest to youngest, so the youngest wins. An entry that has already retired takes no part.
- R8: With no matching pending entry, `lk_hit` is low and `lk_data` equals the `lk_memdata` of the lookup cycle.
- R9: One cycle after a store with `st_miss` high is accepted, `inv_valid` pulses with `inv_index` equal to the low INDEX_W bits of its word address. Stores that are not misses, and stores discarded while full, raise no invalidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request from the cache |
| st_addr | input | 30 | Store word address |
| st_data | input | 32 | Store data |
| st_be | input | 4 | Store byte enables, bit i for byte lane i |
| st_miss | input | 1 | Store missed in the cache |
| st_stall | output | 1 | Queue full; writer must hold |
| inv_valid | output | 1 | Invalidate strobe for a cache line |
| inv_index | output | INDEX_W | Line index to invalidate |
| mem_valid | output | 1 | Oldest entry offered to memory |
| mem_ready | input | 1 | Memory takes the offered entry |
| mem_addr | output | 30 | Offered word address |
| mem_data | output | 32 | Offered data |
| mem_be | output | 4 | Offered byte enables |
| lk_valid | input | 1 | Read-miss lookup request |
| lk_addr | input | 30 | Lookup word address |
| lk_memdata | input | 32 | Word returned by memory for the read |
| lk_rvalid | output | 1 | Lookup answer valid |
| lk_hit | output | 1 | At least one pending entry matched |
| lk_data | output | 32 | Memory word with pending bytes overlaid |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a new store arriving while the queue is full and the memory port accepting its oldest entry. The bench fills all slots, then raises a store and `mem_ready` together. It judges the result by the stall staying high and by the exact order of the four entries that drain afterwards, with the new one last. The second pair is a lookup racing the retirement of an entry: the bench drains the oldest of two matching stores and then looks up the same word. The overlay must then reflect only the younger store.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  localparam int WB_ADDR_W = 30;
  localparam int WB_DATA_W = 32;
  localparam int WB_BE_W   = WB_DATA_W / 8;

  typedef struct packed {
    logic [WB_ADDR_W-1:0] addr;
    logic [WB_DATA_W-1:0] data;
    logic [WB_BE_W-1:0]   be;
  } wb_entry_t;
endpackage

// File: rtl/wbuf_store.sv
// Circular entry storage with head/tail pointers and an occupancy count.
// DEPTH must be a power of two.
module wbuf_store
  import wbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    push,
  input  wb_entry_t               push_ent,
  input  logic                    pop,
  output wb_entry_t [DEPTH-1:0]   slots,
  output logic [PTR_W-1:0]        head,
  output logic [CNT_W-1:0]        occ,
  output logic                    full,
  output logic                    empty
);
  wb_entry_t [DEPTH-1:0] mem_q;
  logic [PTR_W-1:0]      wr_q;
  logic [PTR_W-1:0]      rd_q;
  logic [CNT_W-1:0]      occ_q;

  // payload storage: no reset, written at the tail only
  always_ff @(posedge clk) begin
    if (push) mem_q[wr_q] <= push_ent;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= '0;
      rd_q  <= '0;
      occ_q <= '0;
    end else begin
      if (push) wr_q <= wr_q + 1'b1;
      if (pop)  rd_q <= rd_q + 1'b1;
      case ({push, pop})
        2'b10:   occ_q <= occ_q + 1'b1;
        2'b01:   occ_q <= occ_q - 1'b1;
        default: occ_q <= occ_q;
      endcase
    end
  end

  assign slots = mem_q;
  assign head  = rd_q;
  assign occ   = occ_q;
  assign full  = (occ_q == CNT_W'(DEPTH));
  assign empty = (occ_q == '0);
endmodule

// File: rtl/wbuf_lookup.sv
// Associative search of the pending entries; overlays matching bytes
// oldest to youngest on the memory word and registers the answer.
module wbuf_lookup
  import wbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req,
  input  logic [WB_ADDR_W-1:0]   req_addr,
  input  logic [WB_DATA_W-1:0]   mem_word,
  input  wb_entry_t [DEPTH-1:0]  slots,
  input  logic [PTR_W-1:0]       head,
  input  logic [CNT_W-1:0]       occ,
  output logic                   rsp_valid,
  output logic                   rsp_hit,
  output logic [WB_DATA_W-1:0]   rsp_data
);
  logic [WB_DATA_W-1:0] merged;
  logic                 any_hit;
  logic [PTR_W-1:0]     idx;

  always_comb begin
    merged  = mem_word;
    any_hit = 1'b0;
    idx     = head;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head + PTR_W'(k);
      if ((CNT_W'(k) < occ) && (slots[idx].addr == req_addr)) begin
        any_hit = 1'b1;
        for (int b = 0; b < WB_BE_W; b++) begin
          if (slots[idx].be[b]) merged[8*b +: 8] = slots[idx].data[8*b +: 8];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= req;
      if (req) begin
        rsp_hit  <= any_hit;
        rsp_data <= merged;
      end
    end
  end
endmodule

// File: rtl/wbuf_inval.sv
// Registers a one-cycle invalidate for stores that missed in the cache.
module wbuf_inval
  import wbuf_pkg::*;
#(
  parameter int INDEX_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fire,
  input  logic [WB_ADDR_W-1:0] addr,
  output logic                 inv_valid,
  output logic [INDEX_W-1:0]   inv_index
);
  always_ff @(posedge clk) begin
    if (rst) begin
      inv_valid <= 1'b0;
      inv_index <= '0;
    end else begin
      inv_valid <= fire;
      if (fire) inv_index <= addr[INDEX_W-1:0];
    end
  end
endmodule

// File: rtl/wbuf_top.sv
module wbuf_top
  import wbuf_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int INDEX_W = 8,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = PTR_W + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 st_valid,
  input  logic [WB_ADDR_W-1:0] st_addr,
  input  logic [WB_DATA_W-1:0] st_data,
  input  logic [WB_BE_W-1:0]   st_be,
  input  logic                 st_miss,
  output logic                 st_stall,
  output logic                 inv_valid,
  output logic [INDEX_W-1:0]   inv_index,
  output logic                 mem_valid,
  input  logic                 mem_ready,
  output logic [WB_ADDR_W-1:0] mem_addr,
  output logic [WB_DATA_W-1:0] mem_data,
  output logic [WB_BE_W-1:0]   mem_be,
  input  logic                 lk_valid,
  input  logic [WB_ADDR_W-1:0] lk_addr,
  input  logic [WB_DATA_W-1:0] lk_memdata,
  output logic                 lk_rvalid,
  output logic                 lk_hit,
  output logic [WB_DATA_W-1:0] lk_data
);
  wb_entry_t [DEPTH-1:0] slots;
  wb_entry_t             new_ent;
  logic [PTR_W-1:0]      head;
  logic [CNT_W-1:0]      occ;
  logic                  full;
  logic                  empty;
  logic                  pop;
  logic                  push;

  assign new_ent.addr = st_addr;
  assign new_ent.data = st_data;
  assign new_ent.be   = st_be;

  assign pop  = ~empty & mem_ready;
  assign push = st_valid & (~full | pop);

  wbuf_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst      (rst),
    .push     (push),
    .push_ent (new_ent),
    .pop      (pop),
    .slots    (slots),
    .head     (head),
    .occ      (occ),
    .full     (full),
    .empty    (empty)
  );

  wbuf_lookup #(.DEPTH(DEPTH)) u_lookup (
    .clk       (clk),
    .rst       (rst),
    .req       (lk_valid),
    .req_addr  (lk_addr),
    .mem_word  (lk_memdata),
    .slots     (slots),
    .head      (head),
    .occ       (occ),
    .rsp_valid (lk_rvalid),
    .rsp_hit   (lk_hit),
    .rsp_data  (lk_data)
  );

  wbuf_inval #(.INDEX_W(INDEX_W)) u_inval (
    .clk       (clk),
    .rst       (rst),
    .fire      (push & st_miss),
    .addr      (st_addr),
    .inv_valid (inv_valid),
    .inv_index (inv_index)
  );

  assign st_stall  = full;
  assign mem_valid = ~empty;
  assign mem_addr  = slots[head].addr;
  assign mem_data  = slots[head].data;
  assign mem_be    = slots[head].be;
endmodule

// File: rtl/wbuf_chk.sv
module wbuf_chk
  import wbuf_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int INDEX_W = 8,
  localparam int CNT_W  = $clog2(DEPTH) + 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 st_valid,
  input logic [WB_ADDR_W-1:0] st_addr,
  input logic                 st_miss,
  input logic                 st_stall,
  input logic                 inv_valid,
  input logic [INDEX_W-1:0]   inv_index,
  input logic                 mem_valid,
  input logic                 mem_ready,
  input logic [WB_ADDR_W-1:0] mem_addr,
  input logic [WB_DATA_W-1:0] mem_data,
  input logic [WB_BE_W-1:0]   mem_be,
  input logic                 lk_valid,
  input logic [WB_DATA_W-1:0] lk_memdata,
  input logic                 lk_rvalid,
  input logic                 lk_hit,
  input logic [WB_DATA_W-1:0] lk_data,
  input logic [CNT_W-1:0]     occ
);
  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    occ <= CNT_W'(DEPTH));

  // R4
  stall_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    st_stall |-> mem_valid);

  // R4
  full_stays_chk: assert property (@(posedge clk) disable iff (rst)
    st_stall && !mem_ready |=> st_stall);

  // R5
  full_swap_chk: assert property (@(posedge clk) disable iff (rst)
    st_stall && st_valid && mem_ready |=> st_stall);

  // R3
  drain_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data) && $stable(mem_be));

  // R6
  lookup_resp_chk: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> lk_rvalid);

  // R8
  lookup_empty_chk: assert property (@(posedge clk) disable iff (rst)
    lk_valid && !mem_valid |=> !lk_hit && (lk_data == $past(lk_memdata)));

  // R9
  inval_fire_chk: assert property (@(posedge clk) disable iff (rst)
    st_valid && st_miss && !st_stall |=> inv_valid && (inv_index == $past(st_addr[INDEX_W-1:0])));

  // R9
  inval_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !st_valid |=> !inv_valid);
endmodule

bind wbuf_top wbuf_chk #(.DEPTH(DEPTH), .INDEX_W(INDEX_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .st_valid   (st_valid),
  .st_addr    (st_addr),
  .st_miss    (st_miss),
  .st_stall   (st_stall),
  .inv_valid  (inv_valid),
  .inv_index  (inv_index),
  .mem_valid  (mem_valid),
  .mem_ready  (mem_ready),
  .mem_addr   (mem_addr),
  .mem_data   (mem_data),
  .mem_be     (mem_be),
  .lk_valid   (lk_valid),
  .lk_memdata (lk_memdata),
  .lk_rvalid  (lk_rvalid),
  .lk_hit     (lk_hit),
  .lk_data    (lk_data),
  .occ        (occ)
);

// File: tb/wbuf_top_test.sv
module wbuf_top_test;
  localparam int DEPTH   = 4;
  localparam int INDEX_W = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        st_valid = 1'b0;
  logic [29:0] st_addr = '0;
  logic [31:0] st_data = '0;
  logic [3:0]  st_be = '0;
  logic        st_miss = 1'b0;
  logic        st_stall;
  logic        inv_valid;
  logic [INDEX_W-1:0] inv_index;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic [29:0] mem_addr;
  logic [31:0] mem_data;
  logic [3:0]  mem_be;
  logic        lk_valid = 1'b0;
  logic [29:0] lk_addr = '0;
  logic [31:0] lk_memdata = '0;
  logic        lk_rvalid;
  logic        lk_hit;
  logic [31:0] lk_data;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  wbuf_top #(.DEPTH(DEPTH), .INDEX_W(INDEX_W)) uut (
    .clk(clk), .rst(rst),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
    .st_miss(st_miss), .st_stall(st_stall),
    .inv_valid(inv_valid), .inv_index(inv_index),
    .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_be(mem_be),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_memdata(lk_memdata),
    .lk_rvalid(lk_rvalid), .lk_hit(lk_hit), .lk_data(lk_data)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive a store for one edge; caller keeps mem_ready as it wishes
  task automatic push(input logic [29:0] a, input logic [31:0] d, input logic [3:0] be,
                      input logic miss);
    st_valid = 1'b1; st_addr = a; st_data = d; st_be = be; st_miss = miss;
    @(negedge clk);
    st_valid = 1'b0; st_miss = 1'b0;
  endtask

  // check the offered entry, then retire it
  task automatic pop_expect(input string req, input logic [29:0] a, input logic [31:0] d,
                            input logic [3:0] be);
    check(req, {63'd0, mem_valid}, 64'd1);
    check(req, {34'd0, mem_addr}, {34'd0, a});
    check(req, {32'd0, mem_data}, {32'd0, d});
    check(req, {60'd0, mem_be}, {60'd0, be});
    mem_ready = 1'b1;
    @(negedge clk);
    mem_ready = 1'b0;
  endtask

  task automatic lookup(input string req, input logic [29:0] a, input logic [31:0] mw,
                        input logic hit, input logic [31:0] d);
    lk_valid = 1'b1; lk_addr = a; lk_memdata = mw;
    @(negedge clk);
    lk_valid = 1'b0; lk_memdata = 32'hDEAD_BEEF;
    check({req, " rvalid"}, {63'd0, lk_rvalid}, 64'd1);
    check({req, " hit"}, {63'd0, lk_hit}, {63'd0, hit});
    check({req, " data"}, {32'd0, lk_data}, {32'd0, d});
  endtask

  task automatic t_reset;
    check("R1 stall", {63'd0, st_stall}, 64'd0);
    check("R1 mem_valid", {63'd0, mem_valid}, 64'd0);
    check("R1 inv_valid", {63'd0, inv_valid}, 64'd0);
    check("R1 lk_rvalid", {63'd0, lk_rvalid}, 64'd0);
  endtask

  task automatic t_order;
    push(30'h10, 32'h0000_0A0A, 4'hF, 1'b0);
    push(30'h20, 32'h0000_0B0B, 4'h3, 1'b0);
    push(30'h30, 32'h0000_0C0C, 4'h8, 1'b0);
    pop_expect("R2 first",  30'h10, 32'h0000_0A0A, 4'hF);
    pop_expect("R2 second", 30'h20, 32'h0000_0B0B, 4'h3);
    pop_expect("R2 third",  30'h30, 32'h0000_0C0C, 4'h8);
    check("R2 empty after drain", {63'd0, mem_valid}, 64'd0);
  endtask

  task automatic t_hold;
    push(30'h44, 32'h1234_5678, 4'h5, 1'b0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R3 held addr", {34'd0, mem_addr}, {34'd0, 30'h44});
      check("R3 held valid", {63'd0, mem_valid}, 64'd1);
    end
    pop_expect("R3 retire", 30'h44, 32'h1234_5678, 4'h5);
    check("R3 gone", {63'd0, mem_valid}, 64'd0);
  endtask

  task automatic t_full;
    for (int i = 0; i < DEPTH; i++) begin
      check("R4 not full yet", {63'd0, st_stall}, 64'd0);
      push(30'h100 + 30'(i), 32'hF000_0000 + 32'(i), 4'hF, 1'b0);
    end
    check("R4 stall when full", {63'd0, st_stall}, 64'd1);
    push(30'h1FF, 32'h0BAD_0BAD, 4'hF, 1'b0);
    check("R4 still full", {63'd0, st_stall}, 64'd1);
    for (int i = 0; i < DEPTH; i++)
      pop_expect("R4 drain original", 30'h100 + 30'(i), 32'hF000_0000 + 32'(i), 4'hF);
    check("R4 discarded store absent", {63'd0, mem_valid}, 64'd0);
  endtask

  task automatic t_fullpush;
    for (int i = 0; i < DEPTH; i++)
      push(30'h200 + 30'(i), 32'hA000_0000 + 32'(i), 4'h1, 1'b0);
    mem_ready = 1'b1;
    push(30'h2AA, 32'hA0A0_A0A0, 4'h2, 1'b0);
    mem_ready = 1'b0;
    check("R5 stall kept", {63'd0, st_stall}, 64'd1);
    for (int i = 1; i < DEPTH; i++)
      pop_expect("R5 order", 30'h200 + 30'(i), 32'hA000_0000 + 32'(i), 4'h1);
    pop_expect("R5 new tail", 30'h2AA, 32'hA0A0_A0A0, 4'h2);
    check("R5 empty", {63'd0, mem_valid}, 64'd0);
  endtask

  task automatic t_lookup;
    lookup("R8 empty queue", 30'h100, 32'h0102_0304, 1'b0, 32'h0102_0304);
    push(30'h100, 32'h1122_3344, 4'b0011, 1'b0);
    push(30'h200, 32'h9999_9999, 4'b1111, 1'b0);
    push(30'h100, 32'hAABB_CCDD, 4'b0110, 1'b0);
    // oldest then youngest: bytes0,1 from first, bytes1,2 from youngest
    lookup("R7 youngest wins", 30'h100, 32'h5566_7788, 1'b1, 32'h55BB_CC44);
    lookup("R6 single match", 30'h200, 32'h0, 1'b1, 32'h9999_9999);
    lookup("R8 no match", 30'h300, 32'hCAFE_F00D, 1'b0, 32'hCAFE_F00D);
    pop_expect("R7 retire oldest", 30'h100, 32'h1122_3344, 4'b0011);
    lookup("R7 retired not used", 30'h100, 32'h5566_7788, 1'b1, 32'h55BB_CC88);
    pop_expect("R7 drain", 30'h200, 32'h9999_9999, 4'hF);
    pop_expect("R7 drain", 30'h100, 32'hAABB_CCDD, 4'b0110);
  endtask

  task automatic t_inval;
    push(30'h12345, 32'h1, 4'hF, 1'b1);
    check("R9 inv pulse", {63'd0, inv_valid}, 64'd1);
    check("R9 inv index", {56'd0, inv_index}, 64'h45);
    push(30'h00077, 32'h2, 4'hF, 1'b0);
    check("R9 no inv on hit store", {63'd0, inv_valid}, 64'd0);
    push(30'h00078, 32'h3, 4'hF, 1'b0);
    push(30'h00079, 32'h4, 4'hF, 1'b0);
    check("R9 full", {63'd0, st_stall}, 64'd1);
    push(30'h000EE, 32'h5, 4'hF, 1'b1);
    check("R9 no inv on discarded store", {63'd0, inv_valid}, 64'd0);
    pop_expect("R9 miss store buffered", 30'h12345, 32'h1, 4'hF);
    pop_expect("R9 drain", 30'h00077, 32'h2, 4'hF);
    pop_expect("R9 drain", 30'h00078, 32'h3, 4'hF);
    pop_expect("R9 drain", 30'h00079, 32'h4, 4'hF);
    check("R9 empty", {63'd0, mem_valid}, 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_order;
    t_hold;
    t_full;
    t_fullpush;
    t_lookup;
    t_inval;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule